// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands, `x_i` of `M` bits and `y_i` of `N` bits, and drives their full `M+N`-bit product on `z_o`. It is purely combinational: a new product appears in the same cycle as new operands, with no clock and no state. It is meant to sit inside a larger datapath stage that registers its inputs and outputs.

Each partial-product bit is one AND of an `x_i` bit and a `y_i` bit. A grid of adder rows reduces these bits, with one row for each `y_i` bit after the first. Inside a row no carry travels sideways. Every carry moves diagonally into the next row, one weight higher. The first reduction row uses half adders, because no carries exist yet. Every later row uses full adders that add:

- a partial-product bit,
- the shifted sum from the row above,
- the carry from the row above.

The lowest output bit of each row is a finished product bit. When the grid ends, one ripple adder merges the remaining sum and carry vectors into the upper `M` product bits.

Top module: `csa_array_mul`

## Requirements
- R1: `z_o` equals the unsigned product of `x_i` and `y_i` for every operand pair. The product is written as an `M+N`-bit value with bit k of weight 2^k.
- R2: `z_o[0]` equals `x_i[0] & y_i[0]`.
- R3: If either operand is zero, `z_o` is all zeros.
- R4: With both operands at their all-ones maximum, `z_o` equals (2^M-1)(2^N-1). The product fits in `M+N` bits, and no carry is lost beyond bit `M+N-1`.
- R5: If `y_i` is a single set bit at position k, `z_o` equals `x_i` shifted left by k positions. The same holds with the operands' roles swapped.
- R6: If either operand equals one, `z_o` equals the other operand, zero-extended.
- R7: The operand widths are parameters. With `M`=6 and `N`=4, the operands 101010 (binary) and 1011 (binary) give the product 111001110 (binary).
- R8: The output settles within the same clock cycle as an input change. It stays unchanged across a clock edge while the inputs are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | M | Unsigned multiplicand |
| y_i | input | N | Unsigned multiplier; each bit selects one array row |
| z_o | output | M+N | Unsigned product |

## Verification
The diagonal carries of the reduction rows and the ripple carry of the vector-merging adder can both be active for the same operand pair. The rows then feed the merge stage carry vectors that are not all zero, so the merge carry has to travel through the top weights. Operand pairs near all ones provoke this, in particular the 4x4 maximum and the 6x4 directed vector. The 4x4 sweep covers every combination of row carries and merge carries. Each result is judged by comparing `z_o` with a shift-and-add product computed in the bench.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
  typedef enum logic {
    CELL_HALF = 1'b0,
    CELL_FULL = 1'b1
  } cell_kind_e;
endpackage

// File: rtl/csa_cell.sv
module csa_cell #(
  parameter csa_mul_pkg::cell_kind_e KIND = csa_mul_pkg::CELL_FULL
) (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  generate
    if (KIND == csa_mul_pkg::CELL_HALF) begin : g_half
      assign s_o  = a_i ^ b_i;
      assign co_o = a_i & b_i;
      // a half adder sits where no carry can exist yet
      always_comb begin
        AST_HALF_NO_CIN: assert (c_i == 1'b0) else $error("half cell got carry"); // R1
      end
    end else begin : g_full
      assign s_o  = a_i ^ b_i ^ c_i;
      assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
  endgenerate
endmodule

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
  parameter int M = 4,
  parameter int N = 4
) (
  input  logic [M-1:0]        x_i,
  input  logic [N-1:0]        y_i,
  output logic [N-1:0][M-1:0] pp_o
);
  generate
    for (genvar j = 0; j < N; j++) begin : g_row
      for (genvar i = 0; i < M; i++) begin : g_col
        assign pp_o[j][i] = x_i[i] & y_i[j];
      end
    end
  endgenerate

  always_comb begin
    if (x_i == '0 || y_i == '0) begin
      AST_PP_ZERO: assert ($countones(pp_o) == 0) else $error("pp not zero"); // R3
    end
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int M = 4,
  parameter csa_mul_pkg::cell_kind_e KIND = csa_mul_pkg::CELL_FULL
) (
  input  logic [M-1:0] pp_i,
  input  logic [M-1:0] sh_i,
  input  logic [M-1:0] c_i,
  output logic [M-1:0] s_o,
  output logic [M-1:0] c_o
);
  localparam int W = M + 2;

  generate
    for (genvar i = 0; i < M; i++) begin : g_cell
      csa_cell #(.KIND(KIND)) u_cell (
        .a_i (pp_i[i]),
        .b_i (sh_i[i]),
        .c_i (c_i[i]),
        .s_o (s_o[i]),
        .co_o(c_o[i])
      );
    end
  endgenerate

  // the weight entering a row must equal the weight leaving it
  always_comb begin
    AST_ROW_CONSERVE: assert ((W'(s_o) + (W'(c_o) << 1)) == (W'(pp_i) + W'(sh_i) + W'(c_i)))
      else $error("row loses weight"); // R1
  end
endmodule

// File: rtl/csa_merge.sv
module csa_merge #(
  parameter int M = 4
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] s_o
);
  logic [M:0] cy;
  assign cy[0] = 1'b0;

  generate
    for (genvar k = 0; k < M; k++) begin : g_bit
      if (k == 0) begin : g_lsb
        csa_cell #(.KIND(csa_mul_pkg::CELL_HALF)) u_cell (
          .a_i (a_i[k]),
          .b_i (b_i[k]),
          .c_i (cy[k]),
          .s_o (s_o[k]),
          .co_o(cy[k+1])
        );
      end else begin : g_up
        csa_cell #(.KIND(csa_mul_pkg::CELL_FULL)) u_cell (
          .a_i (a_i[k]),
          .b_i (b_i[k]),
          .c_i (cy[k]),
          .s_o (s_o[k]),
          .co_o(cy[k+1])
        );
      end
    end
  endgenerate

  always_comb begin
    AST_NO_OVERFLOW: assert (cy[M] == 1'b0) else $error("merge carry out"); // R4
  end
endmodule

// File: rtl/csa_array_mul.sv
module csa_array_mul #(
  parameter int M = 4,
  parameter int N = 4
) (
  input  logic [M-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [M+N-1:0] z_o
);
  localparam int ZW = M + N;

  logic [N-1:0][M-1:0] pp;
  logic [N-1:0][M-1:0] s_r;
  logic [N-1:0][M-1:0] c_r;

  csa_pp_gen #(.M(M), .N(N)) u_pp (
    .x_i (x_i),
    .y_i (y_i),
    .pp_o(pp)
  );

  assign s_r[0] = pp[0];
  assign c_r[0] = '0;

  generate
    for (genvar j = 1; j < N; j++) begin : g_row
      localparam csa_mul_pkg::cell_kind_e KIND =
        (j == 1) ? csa_mul_pkg::CELL_HALF : csa_mul_pkg::CELL_FULL;
      csa_row #(.M(M), .KIND(KIND)) u_row (
        .pp_i(pp[j]),
        .sh_i({1'b0, s_r[j-1][M-1:1]}),
        .c_i (c_r[j-1]),
        .s_o (s_r[j]),
        .c_o (c_r[j])
      );
    end
    for (genvar j = 0; j < N; j++) begin : g_low
      assign z_o[j] = s_r[j][0];
    end
  endgenerate

  csa_merge #(.M(M)) u_merge (
    .a_i({1'b0, s_r[N-1][M-1:1]}),
    .b_i(c_r[N-1]),
    .s_o(z_o[ZW-1:N])
  );

  always_comb begin
    AST_PRODUCT_EXACT: assert (z_o == ZW'(ZW'(x_i) * ZW'(y_i))) else $error("product wrong"); // R1
    AST_Z0_AND: assert (z_o[0] == (x_i[0] & y_i[0])) else $error("z0 wrong"); // R2
    if (x_i == '0 || y_i == '0) begin
      AST_ZERO_OPERAND: assert (z_o == '0) else $error("zero operand"); // R3
    end
  end
endmodule

// File: tb/csa_array_mul_tb.sv
module csa_array_mul_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] x4, y4;
  logic [7:0] z4;
  logic [5:0] xw;
  logic [3:0] yw;
  logic [9:0] zw;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  csa_array_mul #(.M(4), .N(4)) u_dut (.x_i(x4), .y_i(y4), .z_o(z4));
  csa_array_mul #(.M(6), .N(4)) u_dut_wide (.x_i(xw), .y_i(yw), .z_o(zw));

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int k = 0; k < 8; k++) if (b[k]) acc = acc + (16'(a) << k);
    return acc;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply4(input logic [3:0] a, input logic [3:0] b, input string req);
    @(negedge clk);
    x4 = a; y4 = b;
    #1;
    check(req, 16'(z4), ref_mul(8'(a), 8'(b)));
  endtask

  task automatic applyw(input logic [5:0] a, input logic [3:0] b, input string req);
    @(negedge clk);
    xw = a; yw = b;
    #1;
    check(req, 16'(zw), ref_mul(8'(a), 8'(b)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    x4 = '0; y4 = '0; xw = '0; yw = '0;
    #1;
    check("R3 idle zero", 16'(z4), 16'd0);

    // R1 exhaustive 4x4 sweep, also covers R2
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply4(4'(a), 4'(b), "R1");
        check("R2", 16'(z4[0]), 16'(a[0] & b[0]));
      end
    end

    apply4(4'd0, 4'hF, "R3 x zero");
    check("R3", 16'(z4), 16'd0);
    apply4(4'hF, 4'd0, "R3 y zero");
    check("R3", 16'(z4), 16'd0);

    apply4(4'hF, 4'hF, "R4 max");
    check("R4", 16'(z4), 16'd225);

    for (int k = 0; k < 4; k++) begin
      apply4(4'hB, 4'(1 << k), "R5");
      check("R5 shift y", 16'(z4), 16'(8'hB << k));
      apply4(4'(1 << k), 4'hD, "R5");
      check("R5 shift x", 16'(z4), 16'(8'hD << k));
    end

    apply4(4'd1, 4'h9, "R6");
    check("R6 x one", 16'(z4), 16'h9);
    apply4(4'h7, 4'd1, "R6");
    check("R6 y one", 16'(z4), 16'h7);

    applyw(6'b101010, 4'b1011, "R7 directed");
    check("R7", 16'(zw), 16'b111001110);
    applyw(6'h3F, 4'hF, "R7 R4 wide max");
    check("R4 wide", 16'(zw), 16'd945);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom();
      applyw(r[5:0], r[9:6], "R7 random");
    end

    // R8 held inputs stay put across an edge
    @(negedge clk);
    x4 = 4'hE; y4 = 4'h6;
    #1;
    check("R8 same cycle", 16'(z4), 16'd84);
    @(posedge clk);
    #1;
    check("R8 held", 16'(z4), 16'd84);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule